// File: doc/BRIEF.md
# Encoder Transaction Frame Sequencer

This block runs one half-duplex request/response exchange with an absolute position encoder on a shared RS-485 pair. The host loads two clock counts, one for the request and one for the reply, and then raises a start bit. The sequencer claims the line by asserting transmit-enable. It counts rising edges of an externally generated bit clock until the request length is reached, and then releases the line to the encoder. It then waits for as long as the cable delay lasts. The first falling edge on the response line moves it into reception. At that point the completion target is re-armed to the current count plus the receive length. When the target is reached, the sequencer returns to idle.

The bit clock reaches the serial shifter only while bits are actually moving: during the counted part of transmission and of reception. While the block waits, the clock is held off, so the shifter sees no clock edges from an idle line. The host can use a busy level, a one-cycle completion pulse and a sticky no-response flag. A programmable wait watchdog abandons an exchange when the encoder never answers.

Top module: `enc_frame_seq`

## Requirements
- R1: After reset, the state is idle (code 00). transmit_enable, gated clock, busy, done and the no-response flag are all low.
- R2: A rising edge of start_i seen in idle moves the state to transmit (01) on the next clock. A start level that is held high launches only one exchange. A start edge outside idle is ignored.
- R3: The state is reported on state_o with the encoding idle 00, transmit 01, wait 10, receive 11. Every exchange ends in idle.
- R4: tx_en_o is high only in transmit, and only while the bit count is below the transmit target. It goes low in the same cycle that the count reaches the target.
- R5: The transmit count starts at 0 on launch. Each rising edge of bclk_i in transmit adds one. The cycle after the count equals tx_len_i, the state is wait. A tx_len_i of 0 passes through transmit for one cycle without enabling the driver.
- R6: In wait, the bit count does not advance and sclk_o stays low. Only a falling edge of resp_i moves wait to receive, however long the wait has lasted. Falling edges of resp_i in any other state have no effect.
- R7: On entry to receive, the target becomes (count + rx_len_i) modulo 2^CNT_W. After that many further rising edges of bclk_i, the state returns to idle. An rx_len_i of 0 returns to idle on the cycle after entry.
- R8: sclk_o follows bclk_i only in transmit or receive while the count is below the target. Otherwise it is low.
- R9: busy_o is high whenever the state is not idle. done_o is a one-cycle pulse in the first idle cycle after receive completes.
- R10: If wd_limit_i is non-zero and no falling edge arrives within wd_limit_i+1 cycles of wait, the state returns to idle and no_resp_o is set. The flag holds until the next accepted start. A wd_limit_i of 0 waits without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host start bit (level, edge-filtered) |
| bclk_i | input | 1 | Free-running bit clock from the generator |
| resp_i | input | 1 | Receive data line from the transceiver, idles high |
| tx_len_i | input | CNT_W | Request length in bit clocks |
| rx_len_i | input | CNT_W | Response length in bit clocks |
| wd_limit_i | input | WD_W | Wait watchdog limit in cycles, 0 disables |
| state_o | output | 2 | Frame state code |
| tx_en_o | output | 1 | Transceiver transmit enable |
| sclk_o | output | 1 | Gated bit clock for the serial shifter |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| no_resp_o | output | 1 | Sticky watchdog timeout flag |

## Verification
The bench builds the sequencer with an 8-bit bit counter and a 6-bit watchdog counter. The narrow counter lets a 200-clock request followed by a 100-clock response wrap the re-armed target past 255 in a short run. This exercises the modulo rule of R7. The small watchdog width keeps timeouts short. The bench also drives the bit clock at three different periods, so that the terminal count lands on different phases of the bit clock relative to the system clock.

// File: rtl/enc_seq_pkg.sv
`timescale 1ns/1ps
package enc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TX   = 2'b01,
    ST_WAIT = 2'b10,
    ST_RX   = 2'b11
  } frame_st_e;
endpackage

// File: rtl/seq_edge_det.sv
`timescale 1ns/1ps
module seq_edge_det #(
  parameter bit FALL    = 1'b0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= RST_VAL;
    else         q <= d_i;

  generate
    if (FALL) begin : g_fall
      assign edge_o = q & ~d_i;
    end else begin : g_rise
      assign edge_o = d_i & ~q;
    end
  endgenerate
endmodule

// File: rtl/seq_bit_counter.sv
`timescale 1ns/1ps
module seq_bit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_tx_i,
  input  logic             arm_rx_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] tx_len_i,
  input  logic [CNT_W-1:0] rx_len_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, tgt_q;

  assign hit_o = (cnt_q == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (arm_tx_i) begin
      cnt_q <= '0;
      tgt_q <= tx_len_i;
    end else if (arm_rx_i) begin
      tgt_q <= cnt_q + rx_len_i;  // re-arm relative to current count
    end else if (inc_i && !hit_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_wait_wdog.sv
`timescale 1ns/1ps
module seq_wait_wdog #(
  parameter int WD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [WD_W-1:0] limit_i,
  output logic            expire_o
);
  logic [WD_W-1:0] cnt_q;

  assign expire_o = active_i && (limit_i != '0) && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/enc_frame_seq.sv
`timescale 1ns/1ps
module enc_frame_seq
  import enc_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WD_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bclk_i,
  input  logic             resp_i,
  input  logic [CNT_W-1:0] tx_len_i,
  input  logic [CNT_W-1:0] rx_len_i,
  input  logic [WD_W-1:0]  wd_limit_i,
  output logic [1:0]       state_o,
  output logic             tx_en_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             no_resp_o
);
  frame_st_e state_q, state_d;
  logic start_rise, bclk_rise, resp_fall;
  logic arm_tx, arm_rx, hit, shifting, wd_expire;
  logic done_q, no_resp_q;

  seq_edge_det #(.FALL(1'b0), .RST_VAL(1'b0)) u_start_ed (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(start_i), .edge_o(start_rise));
  seq_edge_det #(.FALL(1'b0), .RST_VAL(1'b0)) u_bclk_ed (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bclk_i), .edge_o(bclk_rise));
  seq_edge_det #(.FALL(1'b1), .RST_VAL(1'b1)) u_resp_ed (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(resp_i), .edge_o(resp_fall));

  assign arm_tx   = (state_q == ST_IDLE) && start_rise;
  assign arm_rx   = (state_q == ST_WAIT) && resp_fall;
  assign shifting = ((state_q == ST_TX) || (state_q == ST_RX)) && !hit;

  seq_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .arm_tx_i(arm_tx), .arm_rx_i(arm_rx),
    .inc_i(bclk_rise && shifting),
    .tx_len_i(tx_len_i), .rx_len_i(rx_len_i),
    .hit_o(hit));

  seq_wait_wdog #(.WD_W(WD_W)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .active_i(state_q == ST_WAIT),
    .limit_i(wd_limit_i),
    .expire_o(wd_expire));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_rise) state_d = ST_TX;
      ST_TX:   if (hit)        state_d = ST_WAIT;
      ST_WAIT: begin
        if (resp_fall)      state_d = ST_RX;
        else if (wd_expire) state_d = ST_IDLE;
      end
      ST_RX:   if (hit)        state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      no_resp_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RX) && hit;
      if (arm_tx)
        no_resp_q <= 1'b0;
      else if ((state_q == ST_WAIT) && !resp_fall && wd_expire)
        no_resp_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign tx_en_o   = (state_q == ST_TX) && !hit;
  assign sclk_o    = bclk_i && shifting;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign no_resp_o = no_resp_q;
endmodule

// File: rtl/enc_frame_seq_chk.sv
`timescale 1ns/1ps
module enc_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] state_o,
  input logic       tx_en_o,
  input logic       sclk_o,
  input logic       done_o,
  input logic       no_resp_o
);
  a_r4_txen_only_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> state_o == 2'b01);

  a_r6_no_sclk_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b10 |-> !sclk_o);

  a_r2_idle_exits_to_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b00 |=> (state_o == 2'b00 || state_o == 2'b01));

  a_r5_tx_exits_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b01 |=> (state_o == 2'b01 || state_o == 2'b10));

  a_r7_rx_exits_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b11 |=> (state_o == 2'b11 || state_o == 2'b00));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (state_o == 2'b00 && $past(state_o) == 2'b11));

  a_r10_timeout_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(no_resp_o) |-> (state_o == 2'b00 && $past(state_o) == 2'b10));
endmodule

bind enc_frame_seq enc_frame_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_o(state_o), .tx_en_o(tx_en_o),
  .sclk_o(sclk_o), .done_o(done_o), .no_resp_o(no_resp_o));

// File: tb/sim_enc_frame_seq.sv
`timescale 1ns/1ps
module sim_enc_frame_seq;
  localparam int CNT_W = 8;
  localparam int WD_W  = 6;
  localparam int CMOD  = 1 << CNT_W;
  localparam int WMOD  = 1 << WD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bclk = 1'b0, resp = 1'b1;
  logic [CNT_W-1:0] tx_len = '0, rx_len = '0;
  logic [WD_W-1:0]  wd_lim = '0;
  logic [1:0] state;
  logic tx_en, sclk, busy, done, no_resp;

  always #5 clk = ~clk;

  enc_frame_seq #(.CNT_W(CNT_W), .WD_W(WD_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bclk_i(bclk), .resp_i(resp),
    .tx_len_i(tx_len), .rx_len_i(rx_len), .wd_limit_i(wd_lim),
    .state_o(state), .tx_en_o(tx_en), .sclk_o(sclk), .busy_o(busy),
    .done_o(done), .no_resp_o(no_resp));

  int n_chk = 0, n_fail = 0;
  string phase = "R1";

  // next-cycle stimulus, applied at negedge
  logic nx_start = 1'b0, nx_resp = 1'b1;
  int   half = 2, bc = 0;

  // behavioural reference
  int m_st = 0, m_cnt = 0, m_tgt = 0, m_wd = 0;
  bit m_done = 0, m_nr = 0, m_sq = 0, m_bq = 0, m_rq = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_tgt = 0; m_wd = 0;
      m_done = 0; m_nr = 0; m_sq = 0; m_bq = 0; m_rq = 1;
    end else begin
      bit srise, brise, rfall;
      srise = start && !m_sq;
      brise = bclk && !m_bq;
      rfall = !resp && m_rq;
      m_done = (m_st == 3) && (m_cnt == m_tgt);
      case (m_st)
        0: if (srise) begin m_st = 1; m_cnt = 0; m_tgt = int'(tx_len); m_nr = 0; end
        1: if (m_cnt == m_tgt) begin m_st = 2; m_wd = 0; end
           else if (brise) m_cnt = (m_cnt + 1) % CMOD;
        2: if (rfall) begin m_st = 3; m_tgt = (m_cnt + int'(rx_len)) % CMOD; end
           else if (wd_lim != 0 && m_wd == int'(wd_lim)) begin m_st = 0; m_nr = 1; end
           else m_wd = (m_wd + 1) % WMOD;
        default: if (m_cnt == m_tgt) m_st = 0;
                 else if (brise) m_cnt = (m_cnt + 1) % CMOD;
      endcase
      m_sq = start; m_bq = bclk; m_rq = resp;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_tx, e_sc;
    e_tx = (m_st == 1) && (m_cnt != m_tgt);
    e_sc = bclk && (m_st == 1 || m_st == 3) && (m_cnt != m_tgt);
    chk(int'(state) == m_st, {phase, " R3 state"}, int'(state), m_st);
    chk(tx_en == e_tx, {phase, " R4 tx_en"}, int'(tx_en), int'(e_tx));
    chk(sclk == e_sc, {phase, " R8 sclk"}, int'(sclk), int'(e_sc));
    chk(busy == (m_st != 0), {phase, " R9 busy"}, int'(busy), int'(m_st != 0));
    chk(done == m_done, {phase, " R9 done"}, int'(done), int'(m_done));
    chk(no_resp == m_nr, {phase, " R10 no_resp"}, int'(no_resp), int'(m_nr));
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = nx_start;
      resp  = nx_resp;
      bc++;
      if (bc >= half) begin bc = 0; bclk = ~bclk; end
      #1 compare();
    end
  endtask

  task automatic wait_st(input int s, input int maxc);
    for (int i = 0; i < maxc && int'(state) != s; i++) cyc(1);
    chk(int'(state) == s, {phase, " reach state"}, int'(state), s);
  endtask

  task automatic pulse_start();
    nx_start = 1'b1; cyc(1); nx_start = 1'b0; cyc(1);
  endtask

  task automatic respond();
    nx_resp = 1'b0; cyc(2); nx_resp = 1'b1; cyc(1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    // R1 reset state
    phase = "R1";
    chk(state == 2'b00 && !tx_en && !sclk && !busy && !done && !no_resp,
        "R1 reset outputs", int'(state), 0);
    cyc(3);

    // R5 R7 normal exchange, bclk period 4
    phase = "R5_R7_basic";
    tx_len = 8'd10; rx_len = 8'd20; wd_lim = '0;
    pulse_start();
    wait_st(2, 200);
    cyc(17);                 // R6 cable delay
    chk(int'(state) == 2, "R6 still waiting", int'(state), 2);
    respond();
    wait_st(0, 400);
    cyc(2);

    // R2 held start launches once; start mid-frame ignored
    phase = "R2_level";
    nx_start = 1'b1; cyc(1);
    wait_st(2, 200);
    cyc(5); respond();
    wait_st(0, 400);
    cyc(10);
    chk(int'(state) == 0, "R2 held start no relaunch", int'(state), 0);
    nx_start = 1'b0; cyc(1);
    pulse_start();
    cyc(3);
    nx_start = 1'b1; cyc(1); nx_start = 1'b0; cyc(1);   // edge during transmit
    wait_st(2, 200);
    nx_start = 1'b1; cyc(1); nx_start = 1'b0; cyc(1);   // edge during wait
    respond();
    wait_st(0, 400);
    cyc(5);
    chk(int'(state) == 0, "R2 busy start ignored", int'(state), 0);

    // R6 response edges outside wait ignored, fast bclk
    phase = "R6_glitch";
    half = 1;
    respond();               // idle
    pulse_start();
    respond();               // transmit
    wait_st(2, 200);
    respond();
    wait_st(0, 400);
    cyc(3);

    // R10 disabled watchdog: wait unbounded
    phase = "R10_nolimit";
    half = 3;
    pulse_start();
    wait_st(2, 200);
    cyc(300);
    chk(int'(state) == 2, "R10 limit 0 keeps waiting", int'(state), 2);
    respond();
    wait_st(0, 400);

    // R10 timeout then clear on next start
    phase = "R10_timeout";
    wd_lim = 6'd20;
    pulse_start();
    wait_st(2, 200);
    cyc(25);
    chk(no_resp == 1'b1, "R10 flag set", int'(no_resp), 1);
    chk(int'(state) == 0, "R10 back to idle", int'(state), 0);
    cyc(5);
    chk(no_resp == 1'b1, "R10 flag sticky", int'(no_resp), 1);
    pulse_start();
    chk(no_resp == 1'b0, "R10 flag cleared", int'(no_resp), 0);
    wait_st(2, 200);
    cyc(4); respond();
    wait_st(0, 400);

    // R5 R7 zero lengths
    phase = "R5_R7_zero";
    half = 2;
    tx_len = '0; rx_len = '0;
    pulse_start();
    cyc(2);
    chk(int'(state) == 2, "R5 zero tx goes to wait", int'(state), 2);
    respond();
    wait_st(0, 20);

    // R7 target wrap modulo 2^CNT_W
    phase = "R7_wrap";
    tx_len = 8'd200; rx_len = 8'd100; wd_lim = '0;
    half = 1;
    pulse_start();
    wait_st(2, 1000);
    cyc(3); respond();
    chk(int'(state) == 3, "R7 receiving after wrap", int'(state), 3);
    wait_st(0, 1000);
    cyc(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule